// File: doc/BRIEF.md
# Binary Up-Counter with Paired Enables and Start Override

This block is a binary up-counter, eight bits wide by default, that advances by one on each rising clock edge while its enable path is open. Two synchronous enable inputs act as a pair. When both are at the same level, the counter runs. When they differ, it holds. A separate start input opens the enable path whatever the pair is doing. A master reset clears the count at once, with no clock needed.

The block is used as a frequency divider or an event/time counter. One enable can gate counting on and off while the other is parked. Alternatively, both can be toggled in turn to stop and resume counting. The count is presented in true and complemented form, both registered. A flag shows whether the most recent clock edge opened the enable path.

Top module: `xor_gated_counter`

## Requirements
- R1: While `mrst_i` is high, `count_o` is all zeros and `run_o` is 1. The clear takes effect as soon as `mrst_i` rises, without a clock edge, and lasts as long as `mrst_i` stays high.
- R2: The first rising clock edge after `mrst_i` falls does not change `count_o`. The edge after that may count.
- R3: With `start_async_i` low and the two enables equal (both 0 or both 1), each rising edge adds one to `count_o`. Bit 0 of `count_o` is the least significant bit.
- R4: With `start_async_i` low and exactly one enable high, a rising edge leaves `count_o` unchanged.
- R5: With `start_async_i` high, each rising edge adds one to `count_o` for all four enable combinations.
- R6: The count wraps from 255 to 0, with no saturation and no terminal flag.
- R7: `count_n_o` is the bitwise inverse of `count_o` at all times, including during reset.
- R8: After each rising edge outside reset, `run_o` is 1 if that edge counted and 0 if it held.
- R9: The enable and start levels present at an edge decide that same edge. A mismatch that first appears just before an edge stops that edge. A resumed count continues from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| mrst_i | input | 1 | Master reset, active high, asserts asynchronously |
| start_async_i | input | 1 | Start override, opens the enable path when high |
| sync_en_a_i | input | 1 | First synchronous enable of the pair |
| sync_en_b_i | input | 1 | Second synchronous enable of the pair |
| count_o | output | 8 | Count value, bit 0 least significant |
| count_n_o | output | 8 | Bitwise complement of count_o |
| run_o | output | 1 | 1 when the last edge advanced the count |

## Verification
The assertions check on every clock edge the step-or-hold outcome chosen by the sampled enables and start input. They also check that the complement bus matches the count, that `run_o` records the decision, and that the release edge is ignored. Only the bench's scenarios can show the clock-free clear that happens in the middle of a cycle. The bench scenarios also cover a full sweep through the wrap point, a resume that picks up from the held value, a mismatch placed just before an edge, and a sweep over all eight input combinations.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;
  typedef enum logic {
    GATE_HOLD = 1'b0,
    GATE_GO   = 1'b1
  } gate_e;

  function automatic gate_e gate_decide(input logic start, input logic en_a, input logic en_b);
    return (start || (en_a == en_b)) ? GATE_GO : GATE_HOLD;
  endfunction
endpackage

// File: rtl/xcnt_rst_release.sv
module xcnt_rst_release (
  input  logic clk,
  input  logic mrst_i,
  output logic clr_o
);
  logic clr_q;

  always_ff @(posedge clk or posedge mrst_i) begin
    if (mrst_i) clr_q <= 1'b1;
    else        clr_q <= 1'b0;
  end

  assign clr_o = clr_q;

  // R2: the release flag lasts exactly one edge once reset is low
  assert_release_once_R2: assert property (@(posedge clk) disable iff (mrst_i)
    clr_q |=> !clr_q);
endmodule

// File: rtl/xcnt_gate.sv
module xcnt_gate
  import xcnt_pkg::*;
(
  input  logic clk,
  input  logic mrst_i,
  input  logic clr_i,
  input  logic start_i,
  input  logic en_a_i,
  input  logic en_b_i,
  output logic step_o,
  output logic run_o
);
  gate_e decision;
  gate_e run_q;

  always_comb decision = gate_decide(start_i, en_a_i, en_b_i);

  assign step_o = !clr_i && (decision == GATE_GO);

  always_ff @(posedge clk or posedge mrst_i) begin
    if (mrst_i)     run_q <= GATE_GO;
    else if (clr_i) run_q <= GATE_GO;
    else            run_q <= decision;
  end

  assign run_o = (run_q == GATE_GO);

  // R8: the flag records the decision sampled at the previous edge
  assert_flag_tracks_R8: assert property (@(posedge clk) disable iff (mrst_i)
    !clr_i |=> run_o == $past(start_i || (en_a_i == en_b_i)));
  // R5: the start input forces a step outside the release edge
  assert_start_wins_R5: assert property (@(posedge clk) disable iff (mrst_i)
    (!clr_i && start_i) |-> step_o);
endmodule

// File: rtl/xcnt_bit.sv
module xcnt_bit (
  input  logic clk,
  input  logic mrst_i,
  input  logic clr_i,
  input  logic tog_i,
  output logic q_o,
  output logic qn_o
);
  always_ff @(posedge clk or posedge mrst_i) begin
    if (mrst_i) begin
      q_o  <= 1'b0;
      qn_o <= 1'b1;
    end else if (clr_i) begin
      q_o  <= 1'b0;
      qn_o <= 1'b1;
    end else if (tog_i) begin
      q_o  <= ~q_o;
      qn_o <= ~qn_o;
    end
  end

  // R7: the true and complement flops never agree
  assert_pair_differs_R7: assert property (@(posedge clk) q_o != qn_o);
endmodule

// File: rtl/xor_gated_counter.sv
module xor_gated_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             mrst_i,
  input  logic             start_async_i,
  input  logic             sync_en_a_i,
  input  logic             sync_en_b_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] count_n_o,
  output logic             run_o
);
  localparam int CARRY_W = WIDTH + 1;

  logic               clr;
  logic               step;
  logic [CARRY_W-1:0] carry;

  xcnt_rst_release u_release (
    .clk    (clk),
    .mrst_i (mrst_i),
    .clr_o  (clr)
  );

  xcnt_gate u_gate (
    .clk     (clk),
    .mrst_i  (mrst_i),
    .clr_i   (clr),
    .start_i (start_async_i),
    .en_a_i  (sync_en_a_i),
    .en_b_i  (sync_en_b_i),
    .step_o  (step),
    .run_o   (run_o)
  );

  assign carry[0] = step;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign carry[i+1] = carry[i] & count_o[i];
    xcnt_bit u_bit (
      .clk    (clk),
      .mrst_i (mrst_i),
      .clr_i  (clr),
      .tog_i  (carry[i]),
      .q_o    (count_o[i]),
      .qn_o   (count_n_o[i])
    );
  end

  // R3: a matched pair, or the start input, advances the count by one (wrapping, R6)
  assert_step_R3: assert property (@(posedge clk) disable iff (mrst_i)
    (!clr && (start_async_i || (sync_en_a_i == sync_en_b_i)))
      |=> count_o == WIDTH'($past(count_o) + 1'b1));
  // R4: a mismatched pair without start holds the count
  assert_hold_R4: assert property (@(posedge clk) disable iff (mrst_i)
    (!clr && !start_async_i && (sync_en_a_i != sync_en_b_i))
      |=> count_o == $past(count_o));
  // R2: the release edge leaves the count at zero
  assert_release_zero_R2: assert property (@(posedge clk) disable iff (mrst_i)
    clr |=> count_o == '0);
  // R1: reset held means zero count
  assert_reset_zero_R1: assert property (@(posedge clk)
    mrst_i |-> (count_o == '0 && run_o));
  // R7: the complement bus mirrors the count
  assert_complement_R7: assert property (@(posedge clk)
    count_n_o == ~count_o);
endmodule

// File: tb/xor_gated_counter_tb.sv
`timescale 1ns/1ps
module xor_gated_counter_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         mrst;
  logic         start;
  logic         en_a;
  logic         en_b;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_n;
  logic         run;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_cnt;
  logic         exp_run;
  bit           pend;

  always #2.5 clk = ~clk;

  xor_gated_counter #(.WIDTH(W)) dut_i (
    .clk           (clk),
    .mrst_i        (mrst),
    .start_async_i (start),
    .sync_en_a_i   (en_a),
    .sync_en_b_i   (en_b),
    .count_o       (cnt),
    .count_n_o     (cnt_n),
    .run_o         (run)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, cnt, exp_cnt);
    chk({tag, " R7 complement"}, cnt_n, ~exp_cnt);
    chk({tag, " R8 run flag"}, W'(run), W'(exp_run));
  endtask

  // One edge, inputs already stable; the model decides from the levels present at the edge.
  task automatic tick();
    logic go;
    go = start || (en_a == en_b);
    @(posedge clk);
    #1;
    if (mrst) begin
      exp_cnt = '0; exp_run = 1'b1; pend = 1'b1;
    end else if (pend) begin
      pend = 1'b0;
    end else begin
      if (go) exp_cnt = exp_cnt + 1'b1;
      exp_run = go;
    end
  endtask

  task automatic set_in(input logic s, input logic a, input logic b);
    start = s; en_a = a; en_b = b;
  endtask

  task automatic do_reset();
    mrst = 1'b1;
    #1;
    exp_cnt = '0; exp_run = 1'b1; pend = 1'b1;
    tick();
    mrst = 1'b0;
  endtask

  initial begin
    mrst = 1'b1;
    set_in(1'b0, 1'b0, 1'b0);
    exp_cnt = '0; exp_run = 1'b1; pend = 1'b1;
    tick(); tick();
    chk_all("R1 reset state");
    mrst = 1'b0;

    // R2: release edge does not count
    tick();
    chk_all("R2 release edge");
    tick();
    chk_all("R2 second edge counts R3");

    // R3: both low, then both high
    for (int i = 0; i < 6; i++) begin tick(); chk_all("R3 both low"); end
    set_in(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin tick(); chk_all("R3 both high"); end

    // R4: one enable alone holds, then resume from held value (R9)
    set_in(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin tick(); chk_all("R4 only a high"); end
    set_in(1'b0, 1'b1, 1'b1);
    tick(); chk_all("R9 resume from held");
    set_in(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin tick(); chk_all("R4 only b high"); end

    // R5: start overrides a mismatched pair
    set_in(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin tick(); chk_all("R5 start with b only"); end
    set_in(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin tick(); chk_all("R5 start with a only"); end

    // R9: mismatch introduced 1 ns before an edge stops that edge
    set_in(1'b0, 1'b1, 1'b1);
    tick(); chk_all("R9 running before late change");
    #3;
    en_b = 1'b0;
    tick(); chk_all("R9 late mismatch holds");

    // Exhaustive sweep over all eight input combinations, several edges each
    for (int c = 0; c < 8; c++) begin
      set_in(c[2], c[1], c[0]);
      for (int k = 0; k < 3; k++) begin tick(); chk_all("R3 R4 R5 input sweep"); end
    end

    // R6: full sweep through the wrap point
    set_in(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) begin tick(); chk_all("R6 full sweep"); end

    // R1: reset mid-cycle clears with no clock, holds across edges
    #1;
    mrst = 1'b1;
    #0.5;
    exp_cnt = '0; exp_run = 1'b1; pend = 1'b1;
    chk_all("R1 immediate clear");
    set_in(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin tick(); chk_all("R1 held reset"); end
    mrst = 1'b0;
    tick(); chk_all("R2 release with start high");
    tick(); chk_all("R5 count after release");

    // R1 again through the task, then R2 with mismatched pair
    set_in(1'b0, 1'b1, 1'b0);
    do_reset();
    chk_all("R1 task reset");
    tick(); chk_all("R2 release mismatched");
    tick(); chk_all("R4 hold after release");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule